// File: doc/BRIEF.md
# Page-Splitting Serial Flash Program Engine

The engine accepts one write request, made of a start address and a byte count, and stores that many bytes into a serial NOR flash over a four-wire SPI link. The flash accepts at most one page of data per program operation, and an operation must not run past the end of a page. The engine therefore cuts the request into chunks. The first chunk fills only the space left in the starting page. Every later chunk begins on a page boundary and holds up to one full page.

Each chunk takes three chip-select frames. The first frame enables writing. The second sends the program command, the address and the data. The third polls the device status until it reports idle. The data bytes arrive on a valid/ready byte stream, and the engine asks for a byte only while it is shifting program data. A request that falls outside the configured flash window is refused with an error pulse and causes no bus traffic. A request of zero bytes finishes at once. When the last chunk is done, a single-cycle pulse reports how many bytes were written.

Top module: `flash_pgm_engine`

## Requirements
- R1: Every program frame carries between 1 and PAGE_BYTES (default 256) data bytes and stays inside one page. The chunk at address A with R bytes still to write is min(R, PAGE_BYTES - (A mod PAGE_BYTES)) bytes long, and the next chunk starts where this one ended.
- R2: Every program frame is preceded by its own one-byte chip-select frame carrying opcode 0x06 (write enable). Chip select goes high between the two frames.
- R3: A program frame sends opcode 0x02, then the low 24 address bits as three bytes with the most significant byte first, then the data bytes in stream order. Bytes go MSB first in SPI mode 0: the clock idles low, and data is sampled on the rising edge.
- R4: After every program frame the engine opens a status frame with opcode 0x05 and reads status bytes in that frame until bit 0 (busy) reads 0. No write-enable frame for the next chunk starts before that.
- R5: A request with start address below WIN_BASE, or with start plus length above WIN_END (the first address outside the window), raises `err` for one cycle. It produces no chip-select activity and no `done`.
- R6: A request of length zero that lies inside the window gives a `done` pulse with `done_bytes` = 0 and no chip-select frame.
- R7: `s_ready` is high only inside a program frame during the data phase. Exactly the requested number of bytes is taken from the stream.
- R8: `done` is a one-cycle pulse. `done_bytes` equals the requested length.
- R9: `spi_sck` is high only while `spi_cs_n` is low. After reset, `spi_cs_n` is high, and `s_ready`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | ADDR_W | Start address of the write |
| req_len | input | LEN_W | Number of bytes to write |
| busy | output | 1 | A request is in progress |
| s_data | input | 8 | Stream data byte |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Engine takes the byte this cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle completion pulse |
| done_bytes | output | LEN_W | Byte count reported with `done` |
| err | output | 1 | One-cycle range rejection pulse |

## Verification
The assertions assume three things about the inputs. `req_valid` is raised only while `busy` is low and only once per request. `spi_miso` changes only on falling clock edges. `rst_n` is released while no request is pending. The bench keeps to these assumptions. It pulses each request for one cycle and then waits for `done` or `err` before sending the next. Its flash model drives status bits after falling `spi_sck` edges and reports busy for two status reads after every program frame. It throttles `s_valid` with a repeating stall pattern so that the data phase sees gaps in the stream.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_PROG, ST_STAT, ST_GAP, ST_FIN
  } fpe_state_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;

  // bytes that fit from addr to the end of its page, capped by what remains
  function automatic logic [31:0] fpe_chunk_len(input logic [31:0] addr,
                                                input logic [31:0] remain,
                                                input logic [31:0] page);
    logic [31:0] room;
    room = page - (addr % page);
    return (remain < room) ? remain : room;
  endfunction

  function automatic logic fpe_in_window(input logic [63:0] addr, input logic [63:0] len,
                                         input logic [63:0] base, input logic [63:0] lim);
    return (addr >= base) && (addr + len <= lim);
  endfunction
endpackage

// File: rtl/fpe_spi_byte.sv
module fpe_spi_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       active,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);
  logic [3:0] phase;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= '0;
      shreg     <= '0;
      rx        <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        shreg  <= tx;
        phase  <= '0;
      end else if (active) begin
        phase <= phase + 4'd1;
        if (!phase[0]) rx <= {rx[6:0], miso};        // sck rising
        else           shreg <= {shreg[6:0], 1'b0};  // sck falling
        if (phase == 4'hF) begin
          active    <= 1'b0;
          byte_done <= 1'b1;
        end
      end
    end
  end

  assign sck  = active & phase[0];
  assign mosi = active & shreg[7];
endmodule

// File: rtl/flash_pgm_engine.sv
module flash_pgm_engine #(
  parameter int          ADDR_W     = 24,
  parameter int          LEN_W      = 16,
  parameter int          PAGE_BYTES = 256,
  parameter int          GAP_CYC    = 2,
  parameter logic [31:0] WIN_BASE   = 32'h0001_0000,
  parameter logic [31:0] WIN_END    = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              done,
  output logic [LEN_W-1:0]  done_bytes,
  output logic              err
);
  import fpe_pkg::*;

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CLEN_W = PAGE_W + 1;
  localparam int GAP_W  = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  fpe_state_e        st, gap_nxt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  rem, total;
  logic [2:0]        idx;
  logic [CLEN_W-1:0] dcnt;
  logic              infl;

  // named internal events (also seen by the checker)
  logic [CLEN_W-1:0] clen;
  logic              data_phase, in_frame, byte_go, accept;
  logic [7:0]        tx_byte;
  logic [23:0]       addr24;

  logic       sh_active, sh_done;
  logic [7:0] sh_rx;

  assign clen       = CLEN_W'(fpe_chunk_len(32'(cur), 32'(rem), 32'(PAGE_BYTES)));
  assign in_frame   = (st == ST_WREN) || (st == ST_PROG) || (st == ST_STAT);
  assign data_phase = (st == ST_PROG) && (idx == 3'd4);
  assign s_ready    = data_phase && !infl && !sh_active;
  assign byte_go    = in_frame && !infl && !sh_active && (!data_phase || s_valid);
  assign accept     = (st == ST_IDLE) && req_valid;
  assign addr24     = 24'(cur);
  assign busy       = (st != ST_IDLE);
  assign spi_cs_n   = !in_frame;

  always_comb begin
    tx_byte = 8'h00;
    case (st)
      ST_WREN: tx_byte = OP_WREN;
      ST_STAT: tx_byte = (idx == 3'd0) ? OP_RDSR : 8'h00;
      ST_PROG: begin
        case (idx)
          3'd0:    tx_byte = OP_PROG;
          3'd1:    tx_byte = addr24[23:16];
          3'd2:    tx_byte = addr24[15:8];
          3'd3:    tx_byte = addr24[7:0];
          default: tx_byte = s_data;
        endcase
      end
      default: tx_byte = 8'h00;
    endcase
  end

  fpe_spi_byte u_shift (
    .clk(clk), .rst_n(rst_n), .start(byte_go), .tx(tx_byte), .miso(spi_miso),
    .active(sh_active), .sck(spi_sck), .mosi(spi_mosi), .byte_done(sh_done), .rx(sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      gap_nxt    <= ST_IDLE;
      gap_cnt    <= '0;
      cur        <= '0;
      rem        <= '0;
      total      <= '0;
      idx        <= '0;
      dcnt       <= '0;
      infl       <= 1'b0;
      done       <= 1'b0;
      done_bytes <= '0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (byte_go) infl <= 1'b1;
      else if (sh_done) infl <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (!fpe_in_window(64'(req_addr), 64'(req_len), 64'(WIN_BASE), 64'(WIN_END))) begin
            err <= 1'b1;
          end else begin
            cur   <= req_addr;
            rem   <= req_len;
            total <= req_len;
            idx   <= '0;
            st    <= (req_len == '0) ? ST_FIN : ST_WREN;
          end
        end
        ST_WREN: if (sh_done) begin
          st      <= ST_GAP;
          gap_nxt <= ST_PROG;
          idx     <= '0;
          dcnt    <= '0;
        end
        ST_PROG: if (sh_done) begin
          if (idx != 3'd4) idx <= idx + 3'd1;
          else begin
            dcnt <= dcnt + 1'b1;
            if (dcnt + 1'b1 == clen) begin
              st      <= ST_GAP;
              gap_nxt <= ST_STAT;
              idx     <= '0;
            end
          end
        end
        ST_STAT: if (sh_done) begin
          if (idx == 3'd0) idx <= 3'd1;
          else if (!sh_rx[0]) begin
            cur     <= cur + ADDR_W'(clen);
            rem     <= rem - LEN_W'(clen);
            st      <= ST_GAP;
            gap_nxt <= (rem == LEN_W'(clen)) ? ST_FIN : ST_WREN;
            idx     <= '0;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            gap_cnt <= '0;
            st      <= gap_nxt;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        ST_FIN: begin
          done       <= 1'b1;
          done_bytes <= total;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int PAGE_BYTES = 256,
  parameter int CLEN_W     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_sck,
  input logic              s_ready,
  input logic              done,
  input logic              err,
  input logic              data_phase,
  input logic [CLEN_W-1:0] clen,
  input logic [CLEN_W-1:0] dcnt,
  input logic [31:0]       cur_word
);
  logic [31:0] page_off;
  assign page_off = cur_word % PAGE_BYTES;

  a_r1_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (clen != '0) && (32'(clen) <= PAGE_BYTES) && (page_off + 32'(clen) <= PAGE_BYTES));
  a_r1_data_count: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> dcnt < clen);
  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> spi_cs_n && !done);
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err && spi_cs_n);
  a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !spi_cs_n && data_phase);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
endmodule

bind flash_pgm_engine fpe_checker #(.PAGE_BYTES(PAGE_BYTES), .CLEN_W(CLEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .s_ready(s_ready),
  .done(done), .err(err), .data_phase(data_phase), .clen(clen), .dcnt(dcnt),
  .cur_word(32'(cur))
);

// File: tb/flash_pgm_engine_test.sv
`timescale 1ns/1ps
module flash_pgm_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        busy, s_ready, spi_sck, spi_cs_n, spi_mosi, done, err;
  logic [7:0]  s_data = '0;
  logic        s_valid = 1'b0;
  logic        spi_miso = 1'b0;
  logic [15:0] done_bytes;

  always #5 clk = ~clk;

  flash_pgm_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done),
    .done_bytes(done_bytes), .err(err)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  fmem [0:65535];
  logic [7:0]  sh_in = '0, op = '0;
  logic [23:0] paddr = '0;
  int fbits = 0, fbytes = 0, pdcnt = 0, busy_cnt = 0;
  int n_wren = 0, n_prog = 0, n_stat = 0, n_rd = 0;
  int v_r1 = 0, v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r7 = 0, v_r9 = 0;
  bit wren_armed = 0, pend_stat = 0;
  int exp_p = 0, exp_r = 0;

  always @(negedge spi_cs_n) begin
    fbits = 0; fbytes = 0; pdcnt = 0;
  end

  always @(posedge spi_sck) begin
    sh_in = {sh_in[6:0], spi_mosi};
    fbits++;
    if (fbits == 8) begin
      fbits = 0;
      if (fbytes == 0) op = sh_in;
      else if (op == 8'h02) begin
        if (fbytes <= 3) paddr = {paddr[15:0], sh_in};
        else begin
          fmem[16'(paddr[15:0] + 16'(pdcnt))] = sh_in;
          pdcnt++;
        end
      end else if (op == 8'h05) begin
        n_rd++;
        if (busy_cnt > 0) busy_cnt--;
      end
      fbytes++;
    end
  end

  always @(negedge spi_sck)
    spi_miso = (op == 8'h05 && fbytes >= 1 && fbits == 7) ? (busy_cnt > 0) : 1'b0;

  always @(posedge spi_cs_n) begin
    int c;
    case (op)
      8'h06: begin
        if (fbytes != 1) v_r2++;
        if (pend_stat) v_r4++;
        wren_armed = 1; n_wren++;
      end
      8'h02: begin
        if (!wren_armed) v_r2++;
        wren_armed = 0; n_prog++;
        c = 256 - (exp_p % 256);
        if (exp_r < c) c = exp_r;
        if (paddr != 24'(exp_p) || pdcnt != c || pdcnt == 0 || fbytes != pdcnt + 4) v_r1++;
        exp_p += pdcnt; exp_r -= pdcnt;
        busy_cnt = 2; pend_stat = 1;
      end
      8'h05: begin
        if (busy_cnt != 0) v_r4++;
        pend_stat = 0; n_stat++;
      end
      default: v_r3++;
    endcase
  end

  // ---------------- stream source and monitors ----------------
  logic [7:0] seed = '0;
  int  off = 0, stall = 0;
  bit  stream_en = 0, hs_pend = 0, got_done = 0, got_err = 0;
  int  got_bytes = 0;

  initial forever begin
    @(negedge clk);
    if (hs_pend) off++;
    stall++;
    s_valid = stream_en && (stall % 5 != 3);
    s_data  = seed + 8'(off);
    hs_pend = s_valid && s_ready;
    if (s_ready && spi_cs_n) v_r7++;
    if (spi_sck && spi_cs_n) v_r9++;
    if (done) begin got_done = 1; got_bytes = int'(done_bytes); end
    if (err) got_err = 1;
  end

  task automatic clear_model(input int a, input int n);
    n_wren = 0; n_prog = 0; n_stat = 0; n_rd = 0;
    v_r1 = 0; v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r7 = 0; v_r9 = 0;
    wren_armed = 0; pend_stat = 0; busy_cnt = 0;
    exp_p = a; exp_r = n; off = 0; got_done = 0; got_err = 0; got_bytes = -1;
  endtask

  task automatic run_req(input int a, input int n, input bit exp_err, input logic [7:0] sd);
    int chunks, r, p, c, bad;
    bit hung;
    clear_model(a, n);
    seed = sd; stream_en = 1;
    @(negedge clk);
    req_addr = 24'(a); req_len = 16'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    hung = 1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (got_done || got_err) begin hung = 0; break; end
    end
    repeat (4) @(negedge clk);
    stream_en = 0;
    chk(!hung, "R8 request completes", int'(hung), 0);
    chunks = 0; r = n; p = a;
    while (r > 0) begin
      c = 256 - (p % 256);
      if (r < c) c = r;
      chunks++; r -= c; p += c;
    end
    if (exp_err) begin
      chk(got_err == 1, "R5 err pulse", int'(got_err), 1);
      chk(got_done == 0 && n_wren + n_prog + n_stat == 0, "R5 no done and no frames",
          n_wren + n_prog + n_stat + int'(got_done), 0);
    end else if (n == 0) begin
      chk(got_done == 1 && got_bytes == 0, "R6 zero length done count", got_bytes, 0);
      chk(n_wren + n_prog + n_stat == 0, "R6 no frames", n_wren + n_prog + n_stat, 0);
    end else begin
      chk(got_bytes == n, "R8 done_bytes", got_bytes, n);
      chk(n_prog == chunks && v_r1 == 0, "R1 chunk count and sizes", n_prog, chunks);
      chk(n_wren == chunks && v_r2 == 0, "R2 write enable per chunk", n_wren, chunks);
      chk(n_stat == chunks && v_r4 == 0 && n_rd == 3 * chunks, "R4 status polls until idle",
          n_rd, 3 * chunks);
      chk(off == n && v_r7 == 0, "R7 stream bytes taken", off, n);
      chk(v_r9 == 0 && v_r3 == 0, "R9 sck only in frame", v_r9 + v_r3, 0);
      bad = 0;
      for (int k = 0; k < n; k++)
        if (fmem[16'(a + k)] != 8'(sd + 8'(k))) bad++;
      chk(bad == 0, "R3 address and data order", bad, 0);
    end
  endtask

  localparam int NV = 10;
  localparam int  V_ADDR [NV] = '{32'h10000, 32'h100F0, 32'h10180, 32'h101FF, 32'h10300,
                                  32'h0FFFF, 32'h1FFF0, 32'h1FFF0, 32'h10400, 32'h106FF};
  localparam int  V_LEN  [NV] = '{16, 32, 600, 1, 256, 4, 32, 16, 0, 258};
  localparam bit  V_ERR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !s_ready && !busy && !done && !err, "R9 reset state",
        {spi_cs_n, spi_sck, s_ready, busy, done, err}, 6'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_req(V_ADDR[v], V_LEN[v], V_ERR[v], 8'(8'h31 * v + 8'h05));

    // directed: reset in the middle of a long request, then recovery
    clear_model(32'h10800, 400);
    seed = 8'h77; stream_en = 1;
    @(negedge clk);
    req_addr = 24'h010800; req_len = 16'd400; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (700) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !s_ready && !busy, "R9 reset mid request",
        {spi_cs_n, spi_sck, s_ready, busy}, 4'b1000);
    stream_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_req(32'h10900, 300, 0, 8'hA3);
    // directed: request ending exactly at the window edge, then one byte past it
    run_req(32'h1FF00, 256, 0, 8'h11);
    run_req(32'h1FF00, 257, 1, 8'h12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule